// File: doc/BRIEF.md
# Priority Interrupt Controller with Shared Vectors

This block sits between a set of peripheral event lines and a small 8-bit CPU core. Each source has a pending flag that stays set once the source pulses its request line. A pending source takes part in arbitration only when its own enable bit and the global enable flag are both set. Each source has a priority level of high or low. The controller picks one winner, raises a registered request to the CPU and presents a vector index. When the CPU accepts the request, the global enable is cleared automatically. The value the global enable had before the acceptance is pushed onto a small stack, and a return-from-interrupt strobe pops it back.

Some sources are grouped in pairs behind one vector. By default these pairs are sources 12/13, which share vector 12, and sources 14/15, which share vector 14. A handler on a shared vector has to find out which member fired. For this reason, each member keeps its own pending flag, and only software clears that flag. The pending flag of a non-shared source is cleared by hardware when its vector is accepted. Software can set the global enable again inside a handler, which lets a further request nest on top of the one in service.

Software reaches the controller through a byte-wide register port. The register map at the default sixteen sources is:

| Address | Contents |
|---|---|
| 0 | Enable, sources 0..7 |
| 1 | Enable, sources 8..15 |
| 2 | Level, sources 0..7 (1 means high) |
| 3 | Level, sources 8..15 (1 means high) |
| 4 | Pending, sources 0..7 (write 1 to clear) |
| 5 | Pending, sources 8..15 (write 1 to clear) |
| 6 | Control; bit 0 is the global enable |

Inside each pair of registers, source s sits at bit (7 - s mod 8). Bit 7 of address 0 therefore belongs to source 0, which is external interrupt 0.

Top module: `pirq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, the global enable is 0, `irq_o` is 0 and the save stack is empty.
- R2: A pulse on `req_i[s]` sets the pending flag of source s, and the flag stays set. The flag is read at address 4 + s/8, bit 7 - (s mod 8). Writing a 1 to that bit clears the flag. If a request and a clear hit the same flag in the same cycle, the request wins.
- R3: A source is eligible only if three things are all 1: its pending flag, its enable bit (address s/8, bit 7 - (s mod 8)) and the global enable. With no eligible source, `irq_o` stays 0.
- R4: When both high-level and low-level sources are eligible, a high-level source wins.
- R5: Among eligible sources of the same level, the one with the lowest source index wins.
- R6: Sources 12 and 13 present vector 12, and sources 14 and 15 present vector 14. Every other source presents its own index as its vector. Accepting a shared vector leaves the pending flags of both members unchanged.
- R7: Accepting the vector of a non-shared source clears that source's pending flag.
- R8: An acceptance (`ack_i` while `irq_o` is 1) clears the global enable on the next clock edge. `irq_o` falls on that same edge.
- R9: If software sets the global enable again after an acceptance, a pending enabled request is raised again, so it nests before any return.
- R10: Each acceptance pushes the current global enable onto a stack of 4 entries. Pushes made when the stack is full are dropped. A `reti_i` pulse pops the newest entry into the global enable, and it has no effect on an empty stack. A `reti_i` pulse overrides a software write in the same cycle, and it is ignored in a cycle that has an acceptance.
- R11: `irq_o` rises one clock edge after a source becomes eligible. From then until it is accepted, `irq_o` stays 1 and `vec_o` keeps its value, even if a stronger request arrives or the global enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| vec_o | output | 4 | Vector index of the request |
| ack_i | input | 1 | CPU accepts the current request |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
The assertions assume that `ack_i` and `reti_i` are single-cycle pulses from the CPU and that they never occur together. They also assume that `reti_i` is issued only for an acceptance that actually happened. The bench drives every input on the falling edge. It pulses `ack_i` only while `irq_o` is high, and it issues `reti_i` on its own, without `ack_i`. It calls for a return on an empty stack only in the one directed test that checks that this has no effect.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Flat register bit that holds source s (source 0 sits in the top bit).
  function automatic int flat_pos(input int s, input int nsrc);
    return nsrc - 1 - s;
  endfunction

  // Vector presented for source s: shared members fold onto the even index.
  function automatic int vec_of(input int s, input logic is_shared);
    return is_shared ? (s & ~1) : s;
  endfunction

endpackage

// File: rtl/pirq_regfile.sv
module pirq_regfile #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_hw,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               gie,
  output logic               gie_we,
  output logic               gie_wval,
  output logic [NUM_SRC-1:0] pend_s,
  output logic [NUM_SRC-1:0] en_s,
  output logic [NUM_SRC-1:0] lvl_s
);
  import pirq_pkg::*;

  localparam int NBYTE   = NUM_SRC / 8;
  localparam int EN_BASE = 0;
  localparam int LV_BASE = NBYTE;
  localparam int PF_BASE = 2 * NBYTE;
  localparam int CT_ADDR = 3 * NBYTE;

  logic [NUM_SRC-1:0] en_f, lv_f, pend_f, clr_f, clr_s;

  // Flat (register) order versus source order.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    localparam int FP = flat_pos(s, NUM_SRC);
    assign en_s[s]   = en_f[FP];
    assign lvl_s[s]  = lv_f[FP];
    assign pend_f[FP] = pend_s[s];
    assign clr_s[s]  = clr_f[FP];
  end

  // Software write-1-to-clear on the pending bytes.
  always_comb begin
    clr_f = '0;
    if (we) begin
      for (int k = 0; k < NBYTE; k++) begin
        if (int'(addr) == PF_BASE + k) clr_f[NUM_SRC-1-8*k -: 8] = wdata;
      end
    end
  end

  assign gie_we   = we && (int'(addr) == CT_ADDR);
  assign gie_wval = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_f   <= '0;
      lv_f   <= '0;
      pend_s <= '0;
    end else begin
      if (we) begin
        for (int k = 0; k < NBYTE; k++) begin
          if (int'(addr) == EN_BASE + k) en_f[NUM_SRC-1-8*k -: 8] <= wdata;
          if (int'(addr) == LV_BASE + k) lv_f[NUM_SRC-1-8*k -: 8] <= wdata;
        end
      end
      // A new request wins over any clear in the same cycle.
      pend_s <= (pend_s & ~clr_s & ~clr_hw) | req_i;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NBYTE; k++) begin
      if (int'(addr) == EN_BASE + k) rdata = en_f[NUM_SRC-1-8*k -: 8];
      if (int'(addr) == LV_BASE + k) rdata = lv_f[NUM_SRC-1-8*k -: 8];
      if (int'(addr) == PF_BASE + k) rdata = pend_f[NUM_SRC-1-8*k -: 8];
    end
    if (int'(addr) == CT_ADDR) rdata = {7'b0, gie};
  end

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int SW      = 4
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] lvl,
  input  logic               gie,
  output logic               found,
  output logic [SW-1:0]      sel
);
  logic [NUM_SRC-1:0] elig;
  logic               hit_hi, hit_any;
  logic [SW-1:0]      sel_hi, sel_any;

  assign elig = pend & en & {NUM_SRC{gie}};

  // Scan from the top index down so the lowest index is written last.
  always_comb begin
    hit_hi  = 1'b0;
    hit_any = 1'b0;
    sel_hi  = '0;
    sel_any = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig[s]) begin
        hit_any = 1'b1;
        sel_any = SW'(s);
        if (lvl[s]) begin
          hit_hi = 1'b1;
          sel_hi = SW'(s);
        end
      end
    end
  end

  assign found = hit_any;
  assign sel   = hit_hi ? sel_hi : sel_any;

endmodule

// File: rtl/pirq_gie_unit.sv
module pirq_gie_unit #(
  parameter int STACK_DEPTH = 4,
  parameter int DW          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          ret,
  input  logic          sw_we,
  input  logic          sw_val,
  output logic          gie,
  output logic [DW-1:0] depth
);
  logic [STACK_DEPTH-1:0] stk;   // stk[0] is the newest entry

  always_ff @(posedge clk) begin
    if (rst) begin
      gie   <= 1'b0;
      stk   <= '0;
      depth <= '0;
    end else if (take) begin
      gie <= 1'b0;
      if (int'(depth) < STACK_DEPTH) begin
        stk   <= {stk[STACK_DEPTH-2:0], gie};
        depth <= depth + 1'b1;
      end
    end else if (ret) begin
      if (depth != '0) begin
        gie   <= stk[0];
        stk   <= {1'b0, stk[STACK_DEPTH-1:1]};
        depth <= depth - 1'b1;
      end
    end else if (sw_we) begin
      gie <= sw_val;
    end
  end

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int                 NUM_SRC     = 16,
  parameter int                 STACK_DEPTH = 4,
  parameter logic [NUM_SRC-1:0] SHARED      = 16'hF000,
  localparam int                VEC_W       = $clog2(NUM_SRC),
  localparam int                ADDR_W      = $clog2(3 * (NUM_SRC / 8) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  input  logic               ack_i,
  input  logic               reti_i
);
  import pirq_pkg::*;

  localparam int DW = $clog2(STACK_DEPTH + 1);

  logic [NUM_SRC-1:0]            pend_s, en_s, lvl_s, clr_hw;
  logic [NUM_SRC-1:0][VEC_W-1:0] vmap;
  logic                          gie_w, gie_we, gie_wval, found;
  logic [VEC_W-1:0]              sel, src_q;
  logic [DW-1:0]                 depth_w;
  logic                          take_w;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_vec
    assign vmap[s] = VEC_W'(vec_of(s, SHARED[s]));
  end

  assign take_w = ack_i && irq_o;

  always_comb begin
    clr_hw = '0;
    if (take_w && !SHARED[src_q]) clr_hw[src_q] = 1'b1;
  end

  pirq_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_hw(clr_hw),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .gie(gie_w), .gie_we(gie_we), .gie_wval(gie_wval),
    .pend_s(pend_s), .en_s(en_s), .lvl_s(lvl_s)
  );

  pirq_arbiter #(.NUM_SRC(NUM_SRC), .SW(VEC_W)) u_arb (
    .pend(pend_s), .en(en_s), .lvl(lvl_s), .gie(gie_w),
    .found(found), .sel(sel)
  );

  pirq_gie_unit #(.STACK_DEPTH(STACK_DEPTH), .DW(DW)) u_gie (
    .clk(clk), .rst(rst), .take(take_w), .ret(reti_i),
    .sw_we(gie_we), .sw_val(gie_wval), .gie(gie_w), .depth(depth_w)
  );

  // Request register: committed until accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
      src_q <= '0;
    end else if (take_w) begin
      irq_o <= 1'b0;
    end else if (!irq_o && found) begin
      irq_o <= 1'b1;
      vec_o <= vmap[sel];
      src_q <= sel;
    end
  end

endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
  parameter int STACK_DEPTH = 4,
  parameter int VEC_W       = 4,
  parameter int DW          = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             gie,
  input logic [DW-1:0]    depth,
  input logic             take
);
  // R11
  hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_o);

  // R8
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !gie);

  // R3
  rise_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(gie));

  // R10
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(depth) <= STACK_DEPTH);

endmodule

bind pirq_ctrl pirq_ctrl_chk #(.STACK_DEPTH(STACK_DEPTH), .VEC_W(VEC_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o),
  .gie(gie_w), .depth(depth_w), .take(take_w)
);

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [3:0]  vec;
  logic        ack = 1'b0;
  logic        reti = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pirq_ctrl dut (
    .clk(clk), .rst(rst), .req_i(req), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .vec_o(vec),
    .ack_i(ack), .reti_i(reti)
  );

  // {enable flat (bit 15-s = source s), level flat, request mask by source, exp irq, exp vec}
  localparam int NV = 9;
  localparam logic [52:0] TBL [NV] = '{
    {16'hFFFF, 16'h0000, 16'h0208, 1'b1, 4'd3},   // R5 same level, lowest index
    {16'hFFFF, 16'h0040, 16'h0208, 1'b1, 4'd9},   // R4 source 9 high level
    {16'hEFFF, 16'h0000, 16'h0208, 1'b1, 4'd9},   // R3 source 3 disabled
    {16'h0000, 16'h0000, 16'h0020, 1'b0, 4'd0},   // R3 nothing enabled
    {16'hFFFF, 16'h0000, 16'h2000, 1'b1, 4'd12},  // R6 source 13 shares 12
    {16'hFFFF, 16'h0000, 16'h8000, 1'b1, 4'd14},  // R6 source 15 shares 14
    {16'hFFFF, 16'h0001, 16'h8001, 1'b1, 4'd14},  // R4 high level beats index 0
    {16'hFFFF, 16'hFFFF, 16'h0180, 1'b1, 4'd7},   // R5 all high, lowest index
    {16'h8000, 16'h0000, 16'hFFFF, 1'b1, 4'd0}    // R3 enable bit 7 of address 0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 3'(a); wdata = 8'(d);
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 3'(a);
    #1 d = int'(rdata);
  endtask

  task automatic pulse_req(input logic [15:0] m);
    req = m;
    tick(1);
    req = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    tick(1);
    do_reset();

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk("R1 reg", v, 0);
    end

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] en_v, lv_v, rq_v;
      logic        e_irq;
      logic [3:0]  e_vec;
      {en_v, lv_v, rq_v, e_irq, e_vec} = TBL[i];
      do_reset();
      wr(0, en_v[15:8]); wr(1, en_v[7:0]);
      wr(2, lv_v[15:8]); wr(3, lv_v[7:0]);
      pulse_req(rq_v);
      wr(6, 1);
      tick(1);
      chk("R3/R4/R5/R6 irq", int'(irq), int'(e_irq));
      if (e_irq) begin
        chk("R4/R5/R6 vec", int'(vec), int'(e_vec));
        do_ack();
        chk("R8 irq after ack", int'(irq), 0);
        rd(6, v);
        chk("R8 gie after ack", v, 0);
      end
    end

    // R2 sticky flag and write-1-to-clear
    do_reset();
    pulse_req(16'h0400);
    tick(2);
    rd(5, v); chk("R2 flag set", v, 8'h20);
    wr(5, 8'h20);
    rd(5, v); chk("R2 flag cleared", v, 0);

    // R11 stability, R8, R9 nesting, R10 stack order, R7 hardware clear
    do_reset();
    wr(0, 8'hFF); wr(1, 8'hFF);
    pulse_req(16'h0008);
    wr(6, 1);
    tick(1);
    chk("R11 irq up", int'(irq), 1);
    chk("R11 vec", int'(vec), 3);
    pulse_req(16'h0001);
    tick(3);
    chk("R11 vec held", int'(vec), 3);
    wr(6, 0);
    chk("R11 irq held with gie off", int'(irq), 1);
    do_ack();                       // saves gie=0
    chk("R8 irq down", int'(irq), 0);
    wr(6, 1);
    tick(1);
    chk("R9 nested irq", int'(irq), 1);
    chk("R9 nested vec", int'(vec), 0);
    do_ack();                       // saves gie=1
    rd(6, v); chk("R8 gie cleared", v, 0);
    rd(4, v); chk("R7 flags cleared", v, 0);
    do_reti();
    rd(6, v); chk("R10 first pop", v, 1);
    tick(2);
    chk("R3 no eligible source", int'(irq), 0);
    do_reti();
    rd(6, v); chk("R10 second pop", v, 0);
    wr(6, 1);
    do_reti();
    rd(6, v); chk("R10 empty pop ignored", v, 1);

    // R6 shared flags survive acceptance
    do_reset();
    wr(0, 8'hFF); wr(1, 8'hFF);
    wr(3, 8'h04);                   // source 13 high level
    pulse_req(16'h2004);
    wr(6, 1);
    tick(1);
    chk("R6 shared vec", int'(vec), 12);
    do_ack();
    rd(5, v); chk("R6 shared flag kept", v, 8'h04);
    rd(4, v); chk("R6 other flag kept", v, 8'h20);
    wr(5, 8'h04);
    rd(5, v); chk("R2 shared flag cleared by write", v, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule